// File: doc/BRIEF.md
# Descriptor List Address Walker

The walker supplies a DMA engine with the address of each descriptor it must fetch from a list held in host memory. The engine pulses `startIn` to open the list at `baseAddr`. After each descriptor has been fetched, the engine presents the descriptor's fields and pulses `advanceIn`. The walker then works out where the next descriptor lies. Transmit and receive each use their own instance.

Two list layouts are supported. In ring layout, descriptors follow each other at a fixed stride: one 16-byte descriptor plus a programmable gap of `skipLen` 32-bit words. A descriptor whose end-of-ring flag is set sends the walk back to the list base. In chained layout, the descriptor's second address field holds the link to the next descriptor, so that field is never a data buffer.

Along with the descriptor address, the walker passes the buffer addresses the engine should use for the current descriptor. A second buffer of zero length is reported as absent, so the engine can skip it.

Top module: `desc_walker`

## Requirements
- R1: While reset is asserted, and after it until the first start, `curAddr` is 0 and `walkActive` and `chainActive` are 0.
- R2: A `startIn` pulse makes `curAddr` equal to `baseAddr` on the next cycle and sets `walkActive`. The same pulse captures `baseAddr` as the list base and `chainMode` as the layout (1 = chained, 0 = ring), and `chainActive` shows the captured layout.
- R3: In ring layout, an `advanceIn` pulse with the end-of-ring flag clear makes `curAddr` equal to the old `curAddr` + 16 + 4 × `skipLen` on the next cycle, modulo 2^ADDR_W. `skipLen` is sampled on the advance cycle.
- R4: In ring layout, an `advanceIn` pulse with `descEndOfRing` set makes `curAddr` equal to the list base captured at the last start.
- R5: In chained layout, an `advanceIn` pulse makes `curAddr` equal to `descBuf2Addr` on the next cycle, and `descEndOfRing` is ignored.
- R6: While active, `buf1Addr` equals `descBuf1Addr`. In chained layout, `buf2Valid` is 0 and `buf2Addr` is 0. In ring layout, `buf2Valid` is 1 exactly when `descBuf2Len` is nonzero, and `buf2Addr` equals `descBuf2Addr` when valid and 0 otherwise.
- R7: `advanceIn` has no effect while `walkActive` is 0. When `startIn` and `advanceIn` arrive in the same cycle, the start wins.
- R8: Changes on `baseAddr` or `chainMode` after a start have no effect until the next start. Without a start or an accepted advance, `curAddr` holds.
- R9: While `walkActive` is 0, `buf1Addr`, `buf2Addr` and `buf2Valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Open the list at `baseAddr` |
| advanceIn | input | 1 | Step to the next descriptor using the presented fields |
| baseAddr | input | ADDR_W | List base address |
| skipLen | input | SKIP_W | Ring gap between descriptors, in 32-bit words |
| chainMode | input | 1 | Layout: 1 chained, 0 ring (sampled at start) |
| descBuf1Addr | input | ADDR_W | First address field of the fetched descriptor |
| descBuf2Addr | input | ADDR_W | Second address field (link in chained layout) |
| descBuf2Len | input | LEN_W | Length of the second buffer |
| descEndOfRing | input | 1 | End-of-ring flag of the fetched descriptor |
| curAddr | output | ADDR_W | Address of the current descriptor |
| walkActive | output | 1 | A list has been opened |
| chainActive | output | 1 | Captured layout is chained |
| buf1Addr | output | ADDR_W | First buffer address to use |
| buf2Addr | output | ADDR_W | Second buffer address to use, 0 if absent |
| buf2Valid | output | 1 | Second buffer present |

## Verification
The hardest state to reach from the ports is a ring wrap that must return to a base that no longer appears on `baseAddr`. To reach it, the stimulus opens a ring, rewrites `baseAddr` and `chainMode` while the walk is under way, and then advances through a descriptor that carries the end-of-ring flag. The walk must land on the original base with the original layout. Address wrap-around at the top of the address space is reached by opening a ring just below 2^32 and stepping with a nonzero gap.

// File: rtl/dw_pkg.sv
package dw_pkg;
  // Strobes from control to datapath; at most one is high per cycle
  typedef struct packed {
    logic loadBase;    // open the list
    logic stepRing;    // ring step by stride
    logic wrapBase;    // ring end reached, back to captured base
    logic followLink;  // chained layout, take link field
  } walkCtl_t;
endpackage

// File: rtl/dw_ctrl.sv
module dw_ctrl (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic             advanceIn,
  input  logic             chainModeIn,
  input  logic             endOfRingIn,
  output dw_pkg::walkCtl_t ctl,
  output logic             walkActive,
  output logic             chainActive
);
  logic activeQ;
  logic chainQ;
  logic advAccepted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      chainQ  <= 1'b0;
    end else if (startIn) begin
      activeQ <= 1'b1;
      chainQ  <= chainModeIn;
    end
  end

  // start has priority; advance counts only on an open list
  assign advAccepted = advanceIn && activeQ && !startIn;

  always_comb begin
    ctl            = '0;
    ctl.loadBase   = startIn;
    ctl.followLink = advAccepted && chainQ;
    ctl.wrapBase   = advAccepted && !chainQ && endOfRingIn;
    ctl.stepRing   = advAccepted && !chainQ && !endOfRingIn;
  end

  assign walkActive  = activeQ;
  assign chainActive = chainQ;
endmodule

// File: rtl/dw_datapath.sv
module dw_datapath #(
  parameter int ADDR_W     = 32,
  parameter int SKIP_W     = 5,
  parameter int LEN_W      = 11,
  parameter int DESC_BYTES = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dw_pkg::walkCtl_t  ctl,
  input  logic              walkActive,
  input  logic              chainActive,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [SKIP_W-1:0] skipLen,
  input  logic [ADDR_W-1:0] field1Addr,
  input  logic [ADDR_W-1:0] field2Addr,
  input  logic [LEN_W-1:0]  field2Len,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] buf1Addr,
  output logic [ADDR_W-1:0] buf2Addr,
  output logic              buf2Valid
);
  localparam logic [ADDR_W-1:0] DESC_STEP = ADDR_W'(DESC_BYTES);
  localparam int WORD_SHIFT = $clog2(WORD_BYTES);
  localparam bit WORD_POW2  = (1 << WORD_SHIFT) == WORD_BYTES;

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] curQ;
  logic [ADDR_W-1:0] gapBytes;
  logic [ADDR_W-1:0] ringNext;
  logic [ADDR_W-1:0] nextAddr;

  // gap in bytes: shift when the word size is a power of two, else multiply
  generate
    if (WORD_POW2) begin : g_gapShift
      assign gapBytes = ADDR_W'(skipLen) << WORD_SHIFT;
    end else begin : g_gapMul
      assign gapBytes = ADDR_W'(skipLen) * ADDR_W'(WORD_BYTES);
    end
  endgenerate

  assign ringNext = curQ + DESC_STEP + gapBytes;

  always_comb begin
    nextAddr = curQ;
    if (ctl.loadBase)        nextAddr = baseAddr;
    else if (ctl.followLink) nextAddr = field2Addr;
    else if (ctl.wrapBase)   nextAddr = baseQ;
    else if (ctl.stepRing)   nextAddr = ringNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      curQ  <= '0;
    end else begin
      if (ctl.loadBase) baseQ <= baseAddr;
      curQ <= nextAddr;
    end
  end

  logic field2Present;
  assign field2Present = walkActive && !chainActive && (field2Len != '0);

  assign curAddr   = curQ;
  assign buf1Addr  = walkActive ? field1Addr : '0;
  assign buf2Valid = field2Present;
  assign buf2Addr  = field2Present ? field2Addr : '0;
endmodule

// File: rtl/desc_walker.sv
module desc_walker #(
  parameter int ADDR_W     = 32,
  parameter int SKIP_W     = 5,
  parameter int LEN_W      = 11,
  parameter int DESC_BYTES = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              advanceIn,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [SKIP_W-1:0] skipLen,
  input  logic              chainMode,
  input  logic [ADDR_W-1:0] descBuf1Addr,
  input  logic [ADDR_W-1:0] descBuf2Addr,
  input  logic [LEN_W-1:0]  descBuf2Len,
  input  logic              descEndOfRing,
  output logic [ADDR_W-1:0] curAddr,
  output logic              walkActive,
  output logic              chainActive,
  output logic [ADDR_W-1:0] buf1Addr,
  output logic [ADDR_W-1:0] buf2Addr,
  output logic              buf2Valid
);
  dw_pkg::walkCtl_t ctl;

  dw_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .startIn     (startIn),
    .advanceIn   (advanceIn),
    .chainModeIn (chainMode),
    .endOfRingIn (descEndOfRing),
    .ctl         (ctl),
    .walkActive  (walkActive),
    .chainActive (chainActive)
  );

  dw_datapath #(
    .ADDR_W     (ADDR_W),
    .SKIP_W     (SKIP_W),
    .LEN_W      (LEN_W),
    .DESC_BYTES (DESC_BYTES),
    .WORD_BYTES (WORD_BYTES)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .walkActive  (walkActive),
    .chainActive (chainActive),
    .baseAddr    (baseAddr),
    .skipLen     (skipLen),
    .field1Addr  (descBuf1Addr),
    .field2Addr  (descBuf2Addr),
    .field2Len   (descBuf2Len),
    .curAddr     (curAddr),
    .buf1Addr    (buf1Addr),
    .buf2Addr    (buf2Addr),
    .buf2Valid   (buf2Valid)
  );
endmodule

// File: rtl/dw_checker.sv
module dw_checker #(
  parameter int ADDR_W     = 32,
  parameter int SKIP_W     = 5,
  parameter int LEN_W      = 11,
  parameter int DESC_BYTES = 16,
  parameter int WORD_BYTES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              startIn,
  input logic              advanceIn,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [SKIP_W-1:0] skipLen,
  input logic              chainMode,
  input logic [ADDR_W-1:0] descBuf2Addr,
  input logic [LEN_W-1:0]  descBuf2Len,
  input logic              descEndOfRing,
  input logic [ADDR_W-1:0] curAddr,
  input logic              walkActive,
  input logic              chainActive,
  input logic              buf2Valid
);
  // independent record of the base given at the last start
  logic [ADDR_W-1:0] seenBase;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenBase <= '0;
    else if (startIn) seenBase <= baseAddr;
  end

  logic ringAdv;
  assign ringAdv = walkActive && advanceIn && !startIn && !chainActive;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (curAddr == '0 && !walkActive && !chainActive));

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> (curAddr == $past(baseAddr) && walkActive && chainActive == $past(chainMode)));

  a_r3_ring_step: assert property (@(posedge clk) disable iff (!rstN)
    (ringAdv && !descEndOfRing) |=>
      curAddr == $past(curAddr) + ADDR_W'(DESC_BYTES) + ADDR_W'($past(skipLen)) * ADDR_W'(WORD_BYTES));

  a_r4_ring_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (ringAdv && descEndOfRing) |=> curAddr == $past(seenBase));

  a_r5_chain_link: assert property (@(posedge clk) disable iff (!rstN)
    (walkActive && advanceIn && !startIn && chainActive) |=> curAddr == $past(descBuf2Addr));

  a_r6_chain_no_buf2: assert property (@(posedge clk) disable iff (!rstN)
    (chainActive || descBuf2Len == '0) |-> !buf2Valid);

  a_r7_idle_advance: assert property (@(posedge clk) disable iff (!rstN)
    (!walkActive && !startIn) |=> (!walkActive && $stable(curAddr)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!startIn && !advanceIn) |=> ($stable(curAddr) && $stable(chainActive)));

  a_r9_inactive_no_buf: assert property (@(posedge clk) disable iff (!rstN)
    !walkActive |-> !buf2Valid);
endmodule

bind desc_walker dw_checker #(
  .ADDR_W     (ADDR_W),
  .SKIP_W     (SKIP_W),
  .LEN_W      (LEN_W),
  .DESC_BYTES (DESC_BYTES),
  .WORD_BYTES (WORD_BYTES)
) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .startIn       (startIn),
  .advanceIn     (advanceIn),
  .baseAddr      (baseAddr),
  .skipLen       (skipLen),
  .chainMode     (chainMode),
  .descBuf2Addr  (descBuf2Addr),
  .descBuf2Len   (descBuf2Len),
  .descEndOfRing (descEndOfRing),
  .curAddr       (curAddr),
  .walkActive    (walkActive),
  .chainActive   (chainActive),
  .buf2Valid     (buf2Valid)
);

// File: tb/desc_walker_tb_top.sv
module desc_walker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic        advanceIn = 1'b0;
  logic [31:0] baseAddr = '0;
  logic [4:0]  skipLen = '0;
  logic        chainMode = 1'b0;
  logic [31:0] descBuf1Addr = '0;
  logic [31:0] descBuf2Addr = '0;
  logic [10:0] descBuf2Len = '0;
  logic        descEndOfRing = 1'b0;
  logic [31:0] curAddr;
  logic        walkActive;
  logic        chainActive;
  logic [31:0] buf1Addr;
  logic [31:0] buf2Addr;
  logic        buf2Valid;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  desc_walker dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .advanceIn(advanceIn),
    .baseAddr(baseAddr), .skipLen(skipLen), .chainMode(chainMode),
    .descBuf1Addr(descBuf1Addr), .descBuf2Addr(descBuf2Addr),
    .descBuf2Len(descBuf2Len), .descEndOfRing(descEndOfRing),
    .curAddr(curAddr), .walkActive(walkActive), .chainActive(chainActive),
    .buf1Addr(buf1Addr), .buf2Addr(buf2Addr), .buf2Valid(buf2Valid)
  );

  typedef struct packed {
    logic        doStart;
    logic        chain;
    logic [31:0] base;
    logic [4:0]  skip;
    logic        eor;
    logic [31:0] link;
    logic [31:0] expAddr;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b0, 32'h0000_1000, 5'd0,  1'b0, 32'h0,         32'h0000_1000},
    '{1'b0, 1'b0, 32'h0,         5'd0,  1'b0, 32'h0,         32'h0000_1010},
    '{1'b0, 1'b0, 32'h0,         5'd3,  1'b0, 32'h0,         32'h0000_102C},
    '{1'b0, 1'b0, 32'h0,         5'd31, 1'b0, 32'h0,         32'h0000_10B8},
    '{1'b0, 1'b0, 32'h0,         5'd5,  1'b1, 32'h0,         32'h0000_1000},
    '{1'b1, 1'b1, 32'h0000_2000, 5'd0,  1'b0, 32'h0,         32'h0000_2000},
    '{1'b0, 1'b1, 32'h0,         5'd7,  1'b1, 32'h0000_3450, 32'h0000_3450},
    '{1'b0, 1'b1, 32'h0,         5'd0,  1'b0, 32'h0000_0040, 32'h0000_0040},
    '{1'b1, 1'b0, 32'hFFFF_FFF0, 5'd0,  1'b0, 32'h0,         32'hFFFF_FFF0},
    '{1'b0, 1'b0, 32'h0,         5'd1,  1'b0, 32'h0,         32'h0000_0004}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  task automatic pulseAdvance();
    advanceIn = 1'b1;
    @(negedge clk);
    advanceIn = 1'b0;
  endtask

  initial begin
    #1_600_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 curAddr in reset", curAddr, 32'h0);
    check("R1 walkActive in reset", {31'b0, walkActive}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    // R7: advance before any start is ignored
    descBuf2Addr = 32'h0000_7770;
    descBuf1Addr = 32'h0000_ABC0;
    descBuf2Len  = 11'd64;
    pulseAdvance();
    check("R7 advance while idle curAddr", curAddr, 32'h0);
    check("R7 advance while idle active", {31'b0, walkActive}, 32'h0);
    // R9: buffers hidden while idle
    check("R9 buf1Addr idle", buf1Addr, 32'h0);
    check("R9 buf2Valid idle", {31'b0, buf2Valid}, 32'h0);

    // vector table: R2..R5
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      skipLen = VECS[i].skip;
      descEndOfRing = VECS[i].eor;
      descBuf2Addr = VECS[i].link;
      if (VECS[i].doStart) begin
        baseAddr = VECS[i].base;
        chainMode = VECS[i].chain;
        pulseStart();
        tag = "R2 start";
        check("R2 chainActive", {31'b0, chainActive}, {31'b0, VECS[i].chain});
      end else begin
        pulseAdvance();
        if (VECS[i].chain) tag = "R5 chain link";
        else if (VECS[i].eor) tag = "R4 ring wrap";
        else tag = "R3 ring step";
      end
      check(tag, curAddr, VECS[i].expAddr);
    end
    descEndOfRing = 1'b0;

    // R7: start and advance together, start wins
    baseAddr = 32'h0000_8800;
    chainMode = 1'b0;
    skipLen = 5'd2;
    startIn = 1'b1;
    advanceIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    advanceIn = 1'b0;
    check("R7 start beats advance", curAddr, 32'h0000_8800);

    // R8: base and mode rewritten mid-walk have no effect
    baseAddr = 32'h0000_9000;
    chainMode = 1'b1;
    skipLen = 5'd0;
    descBuf2Addr = 32'h0000_0400;
    pulseAdvance();
    check("R8 layout kept after chainMode change", curAddr, 32'h0000_8810);
    repeat (3) @(negedge clk);
    check("R8 hold without advance", curAddr, 32'h0000_8810);
    descEndOfRing = 1'b1;
    pulseAdvance();
    descEndOfRing = 1'b0;
    check("R4 R8 wrap to captured base", curAddr, 32'h0000_8800);

    // R6: buffer outputs in ring layout
    descBuf1Addr = 32'h0001_2340;
    descBuf2Addr = 32'h0005_6780;
    descBuf2Len = 11'd0;
    @(negedge clk);
    check("R6 buf1Addr ring", buf1Addr, 32'h0001_2340);
    check("R6 zero-length buf2 invalid", {31'b0, buf2Valid}, 32'h0);
    check("R6 zero-length buf2 addr", buf2Addr, 32'h0);
    descBuf2Len = 11'd1;
    @(negedge clk);
    check("R6 buf2 valid ring", {31'b0, buf2Valid}, 32'h1);
    check("R6 buf2 addr ring", buf2Addr, 32'h0005_6780);

    // R6: chained layout hides buf2
    chainMode = 1'b1;
    baseAddr = 32'h0000_0C00;
    pulseStart();
    descBuf2Len = 11'd200;
    @(negedge clk);
    check("R6 chain buf2 invalid", {31'b0, buf2Valid}, 32'h0);
    check("R6 chain buf2 addr", buf2Addr, 32'h0);
    check("R6 chain buf1Addr", buf1Addr, 32'h0001_2340);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule